// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. A counter advances on strobes from one of four selectable time bases, optionally divided down by a fixed prescaler. When the count matches a programmed limit, the watchdog latches a timeout flag, can raise an interrupt, and issues a one-cycle reset pulse toward the system reset logic.

Software cannot simply poke the configuration. It first writes a magic unlock key to the counter register, which opens a short configuration window reported by a status bit. Inside that window the limit, the early-refresh window and the control word may be written. Committing the control word closes the window, and a second status bit reports when the new setup is live. The running counter is restarted only by a separate refresh key. Depending on a command-width bit, each key is either a pair of 16-bit writes or one 32-bit write. The time-base inputs are plain enable strobes in the bus clock domain.

Top module: `kwdt_top`

## Requirements
- R1: After reset the control word reads 0x0000_0420 (update-allowed bit 5 and config-done bit 10 set), the limit reads the TOVAL_RST parameter (0x1000), the window and counter read 0, and both `irq` and `wdogRst` are low.
- R2: With bit 13 clear, unlock happens only when 0xC520 and then 0xD928 are written to offset 0x4 with no other counter-register write in between; afterwards bit 11 of the control word reads 1. Any other counter-register write aborts the pending sequence without effect.
- R3: With bit 13 set, a single write of 0xD928C520 to offset 0x4 unlocks and a single write of 0xB480A602 refreshes; the 16-bit word pairs then have no effect.
- R4: While bit 11 reads 0, writes to the limit (offset 0x8), the window (offset 0xC) and all control-word bits except the flag at bit 14 are ignored.
- R5: The unlocked state lasts exactly UNLOCK_CYC (256) bus cycles after the unlocking write unless a control-word write ends it earlier.
- R6: An unlock clears bit 10; a control-word write while unlocked applies the new settings, clears the counter at once, and bit 10 reads 1 again one cycle later.
- R7: With enable bit 7 set, the counter advances once per strobe of the source picked by bits 9:8 (00 every bus cycle, 01/10/11 the `clkStb` bits 0/1/2); strobes of other sources have no effect.
- R8: With prescaler bit 12 set, the counter advances once per 256 strobes of the selected source.
- R9: A counting strobe that finds the counter equal to the limit sets flag bit 14, drives `wdogRst` high for the next cycle and restarts the counter at 0, so the first timeout comes limit+1 counting strobes after a restart.
- R10: `irq` is high exactly when bit 14 and interrupt-enable bit 6 are both set; writing 1 to bit 14 clears the flag even while locked.
- R11: A completed refresh key clears the counter; an aborted or partial refresh leaves it running.
- R12: With a nonzero window value and the timer enabled, a refresh that finds the counter below the window value sets the flag and pulses `wdogRst`; with a window of 0 no refresh does so.
- R13: Once a control word with bit 5 clear has been applied, further unlock keys are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Byte address; bits 3:2 pick the word |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| clkStb | input | 3 | Enable strobes of the three slower time bases |
| irq | output | 1 | Timeout interrupt level |
| wdogRst | output | 1 | One-cycle reset request |

## Verification
The assertions check on every cycle that the unlocked state only begins right after a counter-register write, never outlasts its window and never returns after a lockout, that the limit only changes after an unlocked cycle, that a refresh leaves the counter at zero, that config-done only rises two cycles after an applied control word, and that every reset pulse comes from an enabled timer with the flag set. The key sequences themselves, the exact timeout count for each limit, prescaler boundaries, source selection, the early-refresh violation and the write-one-to-clear behaviour all depend on chosen stimulus and are shown only by the bench's scenarios and sweeps.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int TW = 16;

  localparam logic [1:0] W_CS  = 2'd0;
  localparam logic [1:0] W_CNT = 2'd1;
  localparam logic [1:0] W_TOV = 2'd2;
  localparam logic [1:0] W_WIN = 2'd3;

  localparam logic [15:0] K_UNLK_LO = 16'hC520;
  localparam logic [15:0] K_UNLK_HI = 16'hD928;
  localparam logic [15:0] K_REF_LO  = 16'hA602;
  localparam logic [15:0] K_REF_HI  = 16'hB480;

  localparam int B_UPD   = 5;
  localparam int B_INTEN = 6;
  localparam int B_EN    = 7;
  localparam int B_SEL   = 8;
  localparam int B_RCS   = 10;
  localparam int B_ULK   = 11;
  localparam int B_PRES  = 12;
  localparam int B_CMD32 = 13;
  localparam int B_FLAG  = 14;

  typedef struct packed {
    logic          en;
    logic [1:0]    clkSel;
    logic          pres;
    logic [TW-1:0] toval;
    logic [TW-1:0] win;
  } dpCfg_t;

  typedef struct packed {
    logic refresh;
    logic reconf;
  } dpStb_t;

  typedef enum logic [1:0] {KS_IDLE, KS_UNLK1, KS_REF1} keySt_t;
endpackage

// File: rtl/kwdt_dp.sv
module kwdt_dp
  import kwdt_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCfg_t        cfg,
  input  dpStb_t        stb,
  input  logic [2:0]    clkStb,
  output logic [TW-1:0] cnt,
  output logic          fire,
  output logic          wdogRst
);
  logic [3:0] srcVec;
  logic       srcStb;
  logic       restart;
  logic       tick;
  logic       expire;
  logic       violation;

  assign srcVec  = {clkStb, 1'b1};
  assign srcStb  = srcVec[cfg.clkSel];
  assign restart = stb.refresh | stb.reconf;

  generate
    if (PRE_W > 0) begin : g_pre
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                preCnt <= '0;
        else if (restart)                         preCnt <= '0;
        else if (cfg.en && srcStb && cfg.pres)    preCnt <= preCnt + 1'b1;
      end
      assign tick = cfg.en && srcStb && (!cfg.pres || (&preCnt));
    end else begin : g_nopre
      assign tick = cfg.en && srcStb;
    end
  endgenerate

  assign expire    = tick && !restart && (cnt == cfg.toval);
  assign violation = stb.refresh && cfg.en && (cfg.win != '0) && (cnt < cfg.win);
  assign fire      = expire | violation;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (restart) cnt <= '0;
    else if (expire)  cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wdogRst <= 1'b0;
    else       wdogRst <= fire;
  end
endmodule

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import kwdt_pkg::*;
#(
  parameter int            UNLOCK_CYC = 256,
  parameter logic [TW-1:0] TOVAL_RST  = 16'h1000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    busAddr,
  input  logic          busWr,
  input  logic [31:0]   busWdata,
  output logic [31:0]   busRdata,
  input  logic [TW-1:0] cntIn,
  input  logic          fire,
  output dpCfg_t        cfg,
  output dpStb_t        stb,
  output logic          irq
);
  localparam int UW = (UNLOCK_CYC > 2) ? $clog2(UNLOCK_CYC) : 1;

  logic [1:0]    wordSel;
  logic          cntWr, csWr, cfgWr, tovWr, winWr;
  logic          is16;
  logic [15:0]   lo16;
  keySt_t        keyQ, keyNext;
  logic          unlockHit, refreshHit, unlockOk;

  logic          enQ, intEnQ, updAllowQ, presQ, cmd32Q, flagQ;
  logic [1:0]    clkSelQ;
  logic [TW-1:0] tovalQ, winQ;
  logic          ulkQ, rcsQ, rcsPendQ;
  logic [UW-1:0] ulkCnt;

  assign wordSel = busAddr[3:2];
  assign cntWr   = busWr && (wordSel == W_CNT);
  assign csWr    = busWr && (wordSel == W_CS);
  assign cfgWr   = csWr && ulkQ;
  assign tovWr   = busWr && (wordSel == W_TOV) && ulkQ;
  assign winWr   = busWr && (wordSel == W_WIN) && ulkQ;
  assign is16    = (busWdata[31:16] == 16'h0);
  assign lo16    = busWdata[15:0];

  // Key sequencer: two-write 16-bit form or single 32-bit form (R2, R3)
  always_comb begin
    keyNext    = keyQ;
    unlockHit  = 1'b0;
    refreshHit = 1'b0;
    if (cntWr) begin
      if (cmd32Q) begin
        keyNext    = KS_IDLE;
        unlockHit  = (busWdata == {K_UNLK_HI, K_UNLK_LO});
        refreshHit = (busWdata == {K_REF_HI, K_REF_LO});
      end else begin
        case (keyQ)
          KS_IDLE: begin
            if (is16 && lo16 == K_UNLK_LO)     keyNext = KS_UNLK1;
            else if (is16 && lo16 == K_REF_LO) keyNext = KS_REF1;
          end
          KS_UNLK1: begin
            keyNext   = KS_IDLE;
            unlockHit = is16 && (lo16 == K_UNLK_HI);
          end
          KS_REF1: begin
            keyNext    = KS_IDLE;
            refreshHit = is16 && (lo16 == K_REF_HI);
          end
          default: keyNext = KS_IDLE;
        endcase
      end
    end
  end

  assign unlockOk = unlockHit && updAllowQ;  // R13

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyQ <= KS_IDLE;
    else       keyQ <= keyNext;
  end

  // Unlock window (R5) and config-done status (R6)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ulkQ   <= 1'b0;
      ulkCnt <= '0;
    end else if (cfgWr) begin
      ulkQ   <= 1'b0;
      ulkCnt <= '0;
    end else if (unlockOk) begin
      ulkQ   <= 1'b1;
      ulkCnt <= UW'(UNLOCK_CYC - 1);
    end else if (ulkQ) begin
      if (ulkCnt == '0) ulkQ <= 1'b0;
      else              ulkCnt <= ulkCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rcsQ     <= 1'b1;
      rcsPendQ <= 1'b0;
    end else if (unlockOk) begin
      rcsQ     <= 1'b0;
      rcsPendQ <= 1'b0;
    end else if (cfgWr) begin
      rcsPendQ <= 1'b1;
    end else if (rcsPendQ) begin
      rcsQ     <= 1'b1;
      rcsPendQ <= 1'b0;
    end
  end

  // Configuration registers (R4)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ       <= 1'b0;
      intEnQ    <= 1'b0;
      updAllowQ <= 1'b1;
      clkSelQ   <= 2'b00;
      presQ     <= 1'b0;
      cmd32Q    <= 1'b0;
    end else if (cfgWr) begin
      enQ       <= busWdata[B_EN];
      intEnQ    <= busWdata[B_INTEN];
      updAllowQ <= busWdata[B_UPD];
      clkSelQ   <= busWdata[B_SEL +: 2];
      presQ     <= busWdata[B_PRES];
      cmd32Q    <= busWdata[B_CMD32];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tovalQ <= TOVAL_RST;
      winQ   <= '0;
    end else begin
      if (tovWr) tovalQ <= busWdata[TW-1:0];
      if (winWr) winQ   <= busWdata[TW-1:0];
    end
  end

  // Timeout flag: set wins over write-one-to-clear (R9, R10)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         flagQ <= 1'b0;
    else if (fire)                     flagQ <= 1'b1;
    else if (csWr && busWdata[B_FLAG]) flagQ <= 1'b0;
  end

  assign irq = flagQ & intEnQ;

  assign cfg.en     = enQ;
  assign cfg.clkSel = clkSelQ;
  assign cfg.pres   = presQ;
  assign cfg.toval  = tovalQ;
  assign cfg.win    = winQ;

  assign stb.refresh = refreshHit;
  assign stb.reconf  = cfgWr;

  always_comb begin
    busRdata = '0;
    case (wordSel)
      W_CS: begin
        busRdata[B_UPD]      = updAllowQ;
        busRdata[B_INTEN]    = intEnQ;
        busRdata[B_EN]       = enQ;
        busRdata[B_SEL +: 2] = clkSelQ;
        busRdata[B_RCS]      = rcsQ;
        busRdata[B_ULK]      = ulkQ;
        busRdata[B_PRES]     = presQ;
        busRdata[B_CMD32]    = cmd32Q;
        busRdata[B_FLAG]     = flagQ;
      end
      W_CNT:   busRdata[TW-1:0] = cntIn;
      W_TOV:   busRdata[TW-1:0] = tovalQ;
      default: busRdata[TW-1:0] = winQ;
    endcase
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int            UNLOCK_CYC = 256,
  parameter int            PRE_W      = 8,
  parameter logic [TW-1:0] TOVAL_RST  = 16'h1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  busAddr,
  input  logic        busWr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic [2:0]  clkStb,
  output logic        irq,
  output logic        wdogRst
);
  dpCfg_t        dpCfg;
  dpStb_t        dpStb;
  logic [TW-1:0] cntVal;
  logic          fireStb;

  kwdt_ctrl #(
    .UNLOCK_CYC(UNLOCK_CYC),
    .TOVAL_RST (TOVAL_RST)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWr   (busWr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .cntIn   (cntVal),
    .fire    (fireStb),
    .cfg     (dpCfg),
    .stb     (dpStb),
    .irq     (irq)
  );

  kwdt_dp #(
    .PRE_W(PRE_W)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .cfg    (dpCfg),
    .stb    (dpStb),
    .clkStb (clkStb),
    .cnt    (cntVal),
    .fire   (fireStb),
    .wdogRst(wdogRst)
  );
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
  parameter int UNLOCK_CYC = 256
) (
  input logic        clk,
  input logic        rstN,
  input logic        busWr,
  input logic [3:0]  busAddr,
  input logic        ulk,
  input logic        updAllow,
  input logic [15:0] toval,
  input logic        cfgStb,
  input logic        refreshStb,
  input logic        rcs,
  input logic [15:0] cnt,
  input logic        en,
  input logic        flag,
  input logic        wdogRst
);
  int  ulkRun;
  logic cntWrite;
  assign cntWrite = busWr && (busAddr[3:2] == 2'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ulkRun <= 0;
    else       ulkRun <= (ulk && !cntWrite) ? ulkRun + 1 : 0;
  end

  p_unlock_after_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ulk) |-> $past(cntWrite));

  p_locked_toval_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(toval) |-> $past(ulk));

  p_ulk_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    ulk |-> (ulkRun < UNLOCK_CYC));

  p_rcs_after_cfg_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rcs) |-> $past(cfgStb, 2));

  p_refresh_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    refreshStb |=> (cnt == 16'h0));

  p_rst_enabled_r9: assert property (@(posedge clk) disable iff (!rstN)
    wdogRst |-> $past(en));

  p_rst_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    wdogRst |-> flag);

  p_lockout_r13: assert property (@(posedge clk) disable iff (!rstN)
    !updAllow |-> !ulk);
endmodule

bind kwdt_top kwdt_checker #(.UNLOCK_CYC(UNLOCK_CYC)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busWr     (busWr),
  .busAddr   (busAddr),
  .ulk       (uCtrl.ulkQ),
  .updAllow  (uCtrl.updAllowQ),
  .toval     (dpCfg.toval),
  .cfgStb    (dpStb.reconf),
  .refreshStb(dpStb.refresh),
  .rcs       (uCtrl.rcsQ),
  .cnt       (cntVal),
  .en        (dpCfg.en),
  .flag      (uCtrl.flagQ),
  .wdogRst   (wdogRst)
);

// File: tb/sim_kwdt_top.sv
module sim_kwdt_top;
  localparam logic [31:0] EN   = 32'h0080;
  localparam logic [31:0] IE   = 32'h0040;
  localparam logic [31:0] UPD  = 32'h0020;
  localparam logic [31:0] RCS  = 32'h0400;
  localparam logic [31:0] ULK  = 32'h0800;
  localparam logic [31:0] PRES = 32'h1000;
  localparam logic [31:0] C32  = 32'h2000;
  localparam logic [31:0] FLG  = 32'h4000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = 4'h0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic [2:0]  clkStb = 3'b000;
  logic        irq, wdogRst;

  int errors = 0;
  int checks = 0;
  logic mode32 = 1'b0;

  always #4 clk = ~clk;

  kwdt_top u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .clkStb(clkStb),
    .irq(irq), .wdogRst(wdogRst)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busW(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busR(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic unlock16();
    busW(4'h4, 32'h0000_C520);
    busW(4'h4, 32'h0000_D928);
  endtask

  task automatic refresh16();
    busW(4'h4, 32'h0000_A602);
    busW(4'h4, 32'h0000_B480);
  endtask

  task automatic cfgAll(input logic [15:0] tv, input logic [15:0] wv, input logic [31:0] cs);
    if (mode32) busW(4'h4, 32'hD928_C520);
    else        unlock16();
    busW(4'h8, {16'h0, tv});
    busW(4'hC, {16'h0, wv});
    busW(4'h0, cs);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    step(3);
    rstN = 1'b1;
    step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] c;
    int waitN;
    doReset();

    // R1 reset state
    busR(4'h0, v); check("R1 cs", v, 32'h0000_0420);
    busR(4'h8, v); check("R1 toval", v, 32'h0000_1000);
    busR(4'hC, v); check("R1 win", v, 32'h0);
    busR(4'h4, v); check("R1 cnt", v, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 rst", {31'h0, wdogRst}, 32'h0);

    // R4 locked writes ignored
    busW(4'h8, 32'h5);
    busW(4'hC, 32'h9);
    busW(4'h0, 32'h00FF);
    busR(4'h8, v); check("R4 toval locked", v, 32'h0000_1000);
    busR(4'hC, v); check("R4 win locked", v, 32'h0);
    busR(4'h0, v); check("R4 cs locked", v, 32'h0000_0420);

    // R2 interrupted sequence aborts
    busW(4'h4, 32'h0000_C520);
    busW(4'h4, 32'h0000_A602);
    busW(4'h4, 32'h0000_D928);
    busR(4'h0, v); check("R2 abort", v & ULK, 32'h0);

    // R2 / R6 valid unlock
    unlock16();
    busR(4'h0, v); check("R2 R6 unlocked", v, UPD | ULK);
    busW(4'h8, 32'd50);
    busW(4'hC, 32'd0);
    busW(4'h0, EN | IE | UPD);
    busR(4'h0, v); check("R6 cs applied", v, EN | IE | UPD);
    busR(4'h4, v); check("R6 cnt cleared", v, 32'd0);
    step(1);
    busR(4'h0, v); check("R6 done", v, EN | IE | UPD | RCS);
    busR(4'h4, v); check("R7 bus clock", v, 32'd1);

    // R11 refresh and aborted refresh (window 0, so R12 no reset)
    step(5);
    busR(4'h4, v); check("R7 count", v, 32'd6);
    refresh16();
    busR(4'h4, v); check("R11 refresh", v, 32'd0);
    check("R12 win0 no rst", {31'h0, wdogRst}, 32'h0);
    busW(4'h4, 32'h0000_A602);
    busW(4'h4, 32'h0000_1234);
    busR(4'h4, v); check("R11 aborted", v, 32'd4);
    busW(4'h4, 32'h0000_B480);
    busR(4'h4, v); check("R11 lone second word", v, 32'd6);

    // R5 unlock window length
    unlock16();
    step(255);
    busR(4'h0, v); check("R5 still open", v & ULK, ULK);
    step(1);
    busR(4'h0, v); check("R5 closed", v & ULK, 32'h0);
    busW(4'h8, 32'd7);
    busR(4'h8, v); check("R5 R4 toval after close", v, 32'd50);

    // R9 / R10 sweep of limits
    for (int tv = 0; tv < 6; tv++) begin
      logic [31:0] csv;
      csv = EN | UPD | FLG | ((tv % 2 == 1) ? IE : 32'h0);
      cfgAll(tv[15:0], 16'h0, csv);
      waitN = 0;
      while (!wdogRst && waitN < 20) begin
        step(1);
        waitN++;
      end
      check("R9 timeout count", waitN, tv + 1);
      busR(4'h0, v); check("R9 flag", v & FLG, FLG);
      check("R10 irq", {31'h0, irq}, (tv % 2 == 1) ? 32'h1 : 32'h0);
      busR(4'h4, v); check("R9 restart", v, 32'd0);
      step(1);
      check("R9 pulse width", {31'h0, wdogRst}, (tv == 0) ? 32'h1 : 32'h0);
    end

    // R10 write-one-to-clear while locked
    cfgAll(16'd3, 16'd0, EN | UPD);
    step(10);
    cfgAll(16'd3, 16'd0, IE | UPD);
    step(1);
    busR(4'h0, v); check("R10 flag kept", v & FLG, FLG);
    check("R10 irq on", {31'h0, irq}, 32'h1);
    busW(4'h0, 32'h0000_40FF);
    busR(4'h0, v); check("R10 R4 w1c locked", v, IE | UPD | RCS);
    check("R10 irq off", {31'h0, irq}, 32'h0);

    // R12 early refresh violation
    cfgAll(16'd1000, 16'd20, EN | UPD | FLG);
    step(3);
    refresh16();
    check("R12 violation rst", {31'h0, wdogRst}, 32'h1);
    busR(4'h0, v); check("R12 violation flag", v & FLG, FLG);
    step(1);
    check("R12 rst drops", {31'h0, wdogRst}, 32'h0);
    step(30);
    refresh16();
    check("R12 late refresh ok", {31'h0, wdogRst}, 32'h0);
    busR(4'h4, v); check("R12 late refresh clears", v, 32'd0);

    // R8 prescaler boundary
    cfgAll(16'hFFFF, 16'd0, EN | UPD | PRES | FLG);
    step(767);
    busR(4'h4, v); check("R8 before boundary", v, 32'd2);
    step(1);
    busR(4'h4, v); check("R8 at boundary", v, 32'd3);

    // R7 source select sweep
    for (int sel = 1; sel < 4; sel++) begin
      logic [2:0] mine;
      mine = 3'(1 << (sel - 1));
      cfgAll(16'hFFFF, 16'd0, EN | UPD | FLG | (32'(sel) << 8));
      for (int i = 0; i < 20; i++) begin
        clkStb = (i % 2 == 0) ? 3'b111 : ~mine;
        step(1);
      end
      clkStb = 3'b000;
      busR(4'h4, v); check("R7 selected source", v, 32'd10);
    end

    // R3 32-bit command form
    cfgAll(16'd100, 16'd0, C32 | UPD | FLG);
    mode32 = 1'b1;
    step(2);
    unlock16();
    busR(4'h0, v); check("R3 pair ignored", v & ULK, 32'h0);
    busW(4'h4, 32'hD928_C520);
    busR(4'h0, v); check("R3 single unlock", v & ULK, ULK);
    busW(4'h0, C32 | UPD | EN);
    step(10);
    busR(4'h4, c); check("R3 counting", c, 32'd10);
    refresh16();
    busR(4'h4, v); check("R3 R11 pair no refresh", v, c + 32'd4);
    busW(4'h4, 32'hB480_A602);
    busR(4'h4, v); check("R3 R11 single refresh", v, 32'd0);

    // R13 lockout until reset
    cfgAll(16'd100, 16'd0, C32);
    step(2);
    busW(4'h4, 32'hD928_C520);
    busR(4'h0, v); check("R13 unlock ignored", v & ULK, 32'h0);
    busW(4'h8, 32'd9);
    busR(4'h8, v); check("R13 toval kept", v, 32'd100);
    mode32 = 1'b0;
    doReset();
    unlock16();
    busR(4'h0, v); check("R13 unlock after reset", v & ULK, ULK);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule